// File: doc/BRIEF.md
# Bus-Slave Parallel Output Port

This block is a slave peripheral on a 16-bit parallel data bus whose data lines are active-low. It holds an 8-bit control register and a 12-bit output data register. The 12-bit word drives a parallel output port toward downstream equipment. The port holds that value until the register is loaded again.

The block occupies two consecutive addresses above a parameterised base. Address bit 0 picks the register: 0 selects the control register and 1 selects the data register. A master writes a control word first. When that word carries the write bit, the port is armed for exactly one data write. The data write disarms it again.

Reads place register contents on the bus. Each lane is modelled as a drive enable plus a value, and an undriven lane reads as logic 1. In an interrupt-acknowledge cycle the block drives its parameterised device number onto the low lanes. An interrupt request output is raised while the interrupt-enable control bit is set and an internal request input is asserted.

Top module: `bus_output_port`

## Requirements
- R1: After a synchronous active-low reset, the control register, the data register, `port_out`, `wr_armed` and `irq_req` are all 0, and no bus lane is driven.
- R2: A control write latches the inverted bus lanes 0–5 into control bits 0–5 and the inverted lanes 8–9 into control bits 6–7. Control bit 0 is the write-mode bit, bit 1 is the read-mode bit and bit 2 is the interrupt enable. `wr_armed` becomes equal to the new bit 0.
- R3: A data write is ignored unless `wr_armed` is 1. When it is ignored, `port_out` keeps its value.
- R4: An accepted data write clears `wr_armed`, so a second data write without a new write control word is ignored.
- R5: An accepted data write loads `port_out` with the inverse of `bus_data_n[11:0]`.
- R6: A read or write is acted on only when `bus_addr[ADDR_W-1:1]` equals `BASE_ADDR[ADDR_W-1:1]`, the cycle type matches, and `bus_sel` is 1, all at once. Otherwise nothing is driven and no register changes.
- R7: A control-register read drives only lanes 0–5, 8 and 9, each with the inverse of its control bit. Every other lane stays released and reads high.
- R8: A data-register read drives all 16 lanes. Lanes 0–11 carry the inverse of the data bits and lanes 12–15 carry logic 1.
- R9: While `int_ack` is 1, lanes 0 to DEV_W-1 carry the inverse of DEV_NUM and all other lanes are released. This takes priority over any read or write in the same cycle.
- R10: `irq_req` equals control bit 2 AND `irq_src`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_sel | input | 1 | Bus access strobe |
| bus_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_data_n | input | 16 | Active-low write data from bus |
| int_ack | input | 1 | Interrupt-acknowledge cycle |
| irq_src | input | 1 | Internal interrupt request |
| bus_out_en | output | 16 | Per-lane drive enable |
| bus_out_val | output | 16 | Per-lane driven value (bus level, 1 when released) |
| port_out | output | 12 | Parallel output word |
| wr_armed | output | 1 | Data write permitted |
| irq_req | output | 1 | Interrupt request |

## Verification
The bench builds the block with ADDR_W=8, BASE_ADDR=8'h36 and a 6-bit device number of 6'h2B. With these values, addresses 8'h36 and 8'h37 hit, while a neighbour such as 8'h34 differs only in the upper address bits. The device number has both set and clear bits inside its lane range, so a stuck or shifted lane in the interrupt pattern becomes visible. The reused 8-bit address space lets random traffic mix hits and misses often enough to exercise the arming sequence and the ignored-write paths.

// File: rtl/pout_pkg.sv
package pout_pkg;
    localparam int LANES  = 16;
    localparam int DATA_W = 12;
    localparam int CTL_W  = 8;
    localparam int CB_WR  = 0;
    localparam int CB_RD  = 1;
    localparam int CB_IEN = 2;

    typedef struct packed {
        logic [CTL_W-1:0]  ctl;
        logic [DATA_W-1:0] data;
        logic              armed;
    } pout_state_t;

    // control bits 0-5 sit on lanes 0-5, bits 6-7 on lanes 8-9
    function automatic logic [CTL_W-1:0] ctl_from_lanes(input logic [LANES-1:0] v);
        return {v[9:8], v[5:0]};
    endfunction
endpackage

// File: rtl/pout_decode.sv
module pout_decode #(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_sel,
    input  logic              bus_rd,
    input  logic              int_ack,
    output logic              ctl_wr,
    output logic              dat_wr,
    output logic              ctl_rd,
    output logic              dat_rd,
    output logic              irq_cyc
);
    logic hit;

    always_comb begin
        hit     = bus_sel && !int_ack && (bus_addr[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]);
        ctl_wr  = hit && !bus_rd && !bus_addr[0];
        dat_wr  = hit && !bus_rd &&  bus_addr[0];
        ctl_rd  = hit &&  bus_rd && !bus_addr[0];
        dat_rd  = hit &&  bus_rd &&  bus_addr[0];
        irq_cyc = int_ack;
    end
endmodule

// File: rtl/pout_regs.sv
module pout_regs
    import pout_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              dat_wr,
    input  logic [LANES-1:0]  bus_data_n,
    output logic [CTL_W-1:0]  ctl_o,
    output logic [DATA_W-1:0] data_o,
    output logic              armed_o
);
    pout_state_t st_d, st_q;
    logic [LANES-1:0] wdata;

    always_comb begin
        wdata = ~bus_data_n;
        st_d  = st_q;
        if (ctl_wr) begin
            st_d.ctl   = ctl_from_lanes(wdata);
            st_d.armed = wdata[CB_WR];
        end else if (dat_wr && st_q.armed) begin
            st_d.data  = wdata[DATA_W-1:0];
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl_o   = st_q.ctl;
    assign data_o  = st_q.data;
    assign armed_o = st_q.armed;

    // R3: an unarmed data write leaves the data register untouched
    a_r3_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !armed_o) |=> $stable(data_o));
    // R4: an accepted data write drops the permission
    a_r4_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && armed_o && !ctl_wr) |=> !armed_o);
    // R6: without any write strobe both registers hold
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!dat_wr && !ctl_wr) |=> ($stable(data_o) && $stable(ctl_o)));
endmodule

// File: rtl/pout_busdrv.sv
module pout_busdrv
    import pout_pkg::*;
#(
    parameter int              DEV_W   = 6,
    parameter logic [DEV_W-1:0] DEV_NUM = 6'h15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_rd,
    input  logic              dat_rd,
    input  logic              irq_cyc,
    input  logic [CTL_W-1:0]  ctl,
    input  logic [DATA_W-1:0] data,
    output logic [LANES-1:0]  out_en,
    output logic [LANES-1:0]  out_val
);
    // three lane groups, each with its own strobe
    logic stb_a, stb_b, stb_c;
    always_comb begin
        stb_a = ctl_rd || dat_rd;
        stb_b = dat_rd;
        stb_c = dat_rd;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam bit IN_A = (i <= 5) || (i == 8) || (i == 9);
        localparam bit IN_C = (i >= 12);
        localparam int CI   = (i <= 5) ? i : ((i == 8 || i == 9) ? i - 2 : 0);
        localparam int DI   = (i < DATA_W) ? i : 0;
        localparam int NI   = (i < DEV_W) ? i : 0;
        localparam bit IN_N = (i < DEV_W);
        logic stb, lv;
        always_comb begin
            stb = IN_A ? stb_a : (IN_C ? stb_c : stb_b);
            lv  = 1'b0;
            if (irq_cyc) begin
                out_en[i] = IN_N;
                lv        = IN_N ? DEV_NUM[NI] : 1'b0;
            end else begin
                out_en[i] = stb;
                if (dat_rd)      lv = (i < DATA_W) ? data[DI] : 1'b0;
                else if (ctl_rd) lv = IN_A ? ctl[CI] : 1'b0;
            end
            out_val[i] = out_en[i] ? ~lv : 1'b1;
        end
    end

    // R7: control readback uses only lanes 0-5, 8, 9
    a_r7_ctl_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rd && !irq_cyc) |-> (out_en == 16'h033F));
    // R8: data readback drives every lane
    a_r8_data_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_rd && !irq_cyc) |-> (&out_en));
    // R6: released lanes always read high
    a_r6_release_high: assert property (@(posedge clk) disable iff (!rst_n)
        ((~out_en & ~out_val) == '0));
endmodule

// File: rtl/bus_output_port.sv
module bus_output_port
    import pout_pkg::*;
#(
    parameter int               ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40,
    parameter int               DEV_W     = 6,
    parameter logic [DEV_W-1:0]  DEV_NUM   = 6'h15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_sel,
    input  logic              bus_rd,
    input  logic [15:0]       bus_data_n,
    input  logic              int_ack,
    input  logic              irq_src,
    output logic [15:0]       bus_out_en,
    output logic [15:0]       bus_out_val,
    output logic [11:0]       port_out,
    output logic              wr_armed,
    output logic              irq_req
);
    logic ctl_wr, dat_wr, ctl_rd, dat_rd, irq_cyc;
    logic [CTL_W-1:0] ctl;

    pout_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .bus_addr(bus_addr), .bus_sel(bus_sel), .bus_rd(bus_rd), .int_ack(int_ack),
        .ctl_wr(ctl_wr), .dat_wr(dat_wr), .ctl_rd(ctl_rd), .dat_rd(dat_rd),
        .irq_cyc(irq_cyc));

    pout_regs u_regs (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .dat_wr(dat_wr),
        .bus_data_n(bus_data_n), .ctl_o(ctl), .data_o(port_out), .armed_o(wr_armed));

    pout_busdrv #(.DEV_W(DEV_W), .DEV_NUM(DEV_NUM)) u_drv (
        .clk(clk), .rst_n(rst_n), .ctl_rd(ctl_rd), .dat_rd(dat_rd), .irq_cyc(irq_cyc),
        .ctl(ctl), .data(port_out), .out_en(bus_out_en), .out_val(bus_out_val));

    assign irq_req = ctl[CB_IEN] && irq_src;

    // R10: no request without the source
    a_r10_irq_src: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> irq_src);
    // R9: interrupt cycle drives no lane above the device number
    a_r9_irq_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |-> ((bus_out_en >> DEV_W) == '0));
endmodule

// File: tb/sim_bus_output_port.sv
module sim_bus_output_port;
    localparam int         AW   = 8;
    localparam logic [7:0] BASE = 8'h36;
    localparam int         DW   = 6;
    localparam logic [5:0] DEV  = 6'h2B;

    logic clk = 0, rst_n = 0;
    logic [AW-1:0] bus_addr = '0;
    logic bus_sel = 0, bus_rd = 0, int_ack = 0, irq_src = 0;
    logic [15:0] bus_data_n = '1;
    logic [15:0] bus_out_en, bus_out_val;
    logic [11:0] port_out;
    logic wr_armed, irq_req;

    int total = 0, bad = 0;
    logic [7:0]  m_ctl = 0;
    logic [11:0] m_data = 0;
    logic        m_arm = 0;

    always #4 clk = ~clk;

    bus_output_port #(.ADDR_W(AW), .BASE_ADDR(BASE), .DEV_W(DW), .DEV_NUM(DEV)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_sel(bus_sel), .bus_rd(bus_rd),
        .bus_data_n(bus_data_n), .int_ack(int_ack), .irq_src(irq_src),
        .bus_out_en(bus_out_en), .bus_out_val(bus_out_val), .port_out(port_out),
        .wr_armed(wr_armed), .irq_req(irq_req));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ctl_rd_exp();
        logic [15:0] v = 16'hFFFF;
        v[5:0] = ~m_ctl[5:0];
        v[9:8] = ~m_ctl[7:6];
        return {16'h033F, v};
    endfunction
    function automatic logic [31:0] dat_rd_exp();
        return {16'hFFFF, 4'hF, ~m_data};
    endfunction
    function automatic logic [31:0] irq_exp();
        return {16'h003F, 10'h3FF, ~DEV};
    endfunction
    function automatic logic hit(input logic [7:0] a);
        return a[7:1] == BASE[7:1];
    endfunction

    // one write cycle, logical value v
    task automatic wr(input logic [7:0] a, input logic [15:0] v, input logic sel);
        @(negedge clk);
        bus_addr = a; bus_sel = sel; bus_rd = 0; bus_data_n = ~v;
        @(negedge clk);
        bus_sel = 0; bus_data_n = '1;
        if (sel && hit(a)) begin
            if (!a[0]) begin
                m_ctl = {v[9:8], v[5:0]};
                m_arm = v[0];
            end else if (m_arm) begin
                m_data = v[11:0];
                m_arm = 0;
            end
        end
    endtask

    // read: drive, sample combinational result before the next edge
    task automatic rd(input logic [7:0] a, input logic sel, input logic r, output logic [31:0] res);
        @(negedge clk);
        bus_addr = a; bus_sel = sel; bus_rd = r;
        #1 res = {bus_out_en, bus_out_val};
        @(negedge clk);
        bus_sel = 0; bus_rd = 0;
    endtask

    task automatic chk_state(input string req);
        chk(req, {19'd0, wr_armed, port_out}, {19'd0, m_arm, m_data});
    endtask

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 state", {18'd0, irq_req, wr_armed, port_out}, 32'd0);
        chk("R1 lanes", {bus_out_en, bus_out_val}, {16'h0000, 16'hFFFF});
        // R3 write before arming ignored
        wr(BASE | 8'h1, 16'h0ABC, 1);
        chk("R3 unarmed", {20'd0, port_out}, 32'd0);
        // R2 arm via control write
        wr(BASE, 16'h0301, 1);
        chk("R2 armed", {31'd0, wr_armed}, 32'd1);
        rd(BASE, 1, 1, r);
        chk("R7 ctl read", r, ctl_rd_exp());
        // R5 inversion on write
        wr(BASE | 8'h1, 16'hF5A3, 1);
        chk("R5 inverted load", {20'd0, port_out}, 32'h5A3);
        chk("R4 disarm", {31'd0, wr_armed}, 32'd0);
        // R4 second write blocked
        wr(BASE | 8'h1, 16'h0111, 1);
        chk("R4 second write", {20'd0, port_out}, 32'h5A3);
        rd(BASE | 8'h1, 1, 1, r);
        chk("R8 data read", r, dat_rd_exp());
        // R6 miss cases
        rd(BASE ^ 8'h02, 1, 1, r);
        chk("R6 addr miss", r, {16'h0, 16'hFFFF});
        rd(BASE | 8'h1, 0, 1, r);
        chk("R6 no strobe", r, {16'h0, 16'hFFFF});
        wr(BASE, 16'h0001, 1);
        wr((BASE | 8'h1) ^ 8'h10, 16'h0FFF, 1);
        chk("R6 wrong addr write", {19'd0, wr_armed, port_out}, {19'd0, 1'b1, 12'h5A3});
        // R9 interrupt cycle priority
        @(negedge clk);
        int_ack = 1; bus_addr = BASE; bus_sel = 1; bus_rd = 1;
        #1 chk("R9 irq lanes", {bus_out_en, bus_out_val}, irq_exp());
        @(negedge clk);
        int_ack = 0; bus_sel = 0; bus_rd = 0;
        // R10 interrupt request
        wr(BASE, 16'h0004, 1);
        irq_src = 1; #1;
        chk("R10 irq on", {31'd0, irq_req}, 32'd1);
        wr(BASE, 16'h0000, 1);
        #1 chk("R10 irq off", {31'd0, irq_req}, 32'd0);
        irq_src = 0;
        // random traffic
        for (int n = 0; n < 400; n++) begin
            int op = $urandom_range(0, 5);
            logic [7:0] a = $urandom_range(0, 1) ? (BASE | 8'($urandom_range(0, 1)))
                                                 : 8'($urandom);
            logic [15:0] v = 16'($urandom);
            logic sel = ($urandom_range(0, 7) != 0);
            case (op)
                0, 1: begin wr(a, v, sel); chk_state("R3 random write"); end
                2: begin wr(BASE, v | 16'h1, 1); chk_state("R2 random arm"); end
                3: begin
                    rd(a, sel, 1, r);
                    if (!sel || !hit(a)) chk("R6 random miss", r, {16'h0, 16'hFFFF});
                    else if (a[0])       chk("R8 random data read", r, dat_rd_exp());
                    else                 chk("R7 random ctl read", r, ctl_rd_exp());
                end
                4: begin wr(BASE | 8'h1, v, 1); chk_state("R4 random data write"); end
                default: begin
                    irq_src = v[3]; #1;
                    chk("R10 random irq", {31'd0, irq_req}, {31'd0, m_ctl[2] & v[3]});
                end
            endcase
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule